// File: doc/BRIEF.md
# TPM FIFO Command Exchange Sequencer

This block runs one full command/response exchange with a TPM-style FIFO register interface. A host supplies the command length and a response-buffer limit, then pulses `start`. The block fetches command bytes through a random-access index port. It drives a register-access engine through a request port that carries direction, address and byte count. It returns the response bytes to the host together with their index, and it gives the final response length. The SPI framing, chip select and wait-state handling belong to the attached engine. The block only sequences register transactions.

The exchange always follows the same order. The block checks the command length, signals command-ready, and writes the command in chunks, each chunk preceded by a read of the burst count. It then writes go and polls the status at a fixed spacing until a response is present. It reads the 6-byte response header and reads the response body in chunks, leaving the last byte for a single read on its own. It checks the status around that last byte and returns the device to idle. Any failed check, engine fault or timeout ends the exchange at once, and `err_code` gives the cause.

Top module: `tpm_fifo_xchg`

## Requirements
- R1: On `start`, bytes 2..5 of the command, read big-endian through `cmd_idx`/`cmd_byte`, must equal `cmd_len`, and `cmd_len` must be at least 6. Otherwise the exchange ends with `err_code`=1 and no register request is issued.
- R2: Register offsets are 0x18 for status and 0x24 for the data FIFO, added to `LOC_BASE`. The first request is a 1-byte status write of 0x40 (command ready). The command bytes are then written to the FIFO in order, followed by a 1-byte status write of 0x20 (go). A successful exchange ends with a second 1-byte status write of 0x40.
- R3: Every FIFO chunk is preceded by a 4-byte status read, whose bytes form a little-endian word with the burst count in bits 23:8. While that count is zero, the status read is repeated and no FIFO access occurs.
- R4: Each FIFO chunk length is the smallest of the bytes still to move, the last burst count and 64.
- R5: After go, the block waits `POLL_GAP` cycles before each status poll. It proceeds when bit 7 (valid) and bit 4 (data available) are both set. After `MAX_POLLS` polls without that, it ends with `err_code`=3.
- R6: The response header is a 6-byte FIFO read, and bytes 2..5 hold the total response length big-endian. A length above `rsp_max` or below 7 ends the exchange with `err_code`=4.
- R7: Response bytes 6 up to length-2 are read in chunks. A status read follows, and it must show valid and data available both set, otherwise the exchange ends with `err_code`=5.
- R8: The last response byte is read with a 1-byte FIFO read. The status read that follows must show valid set and data available clear, otherwise the exchange ends with `err_code`=6.
- R9: An engine completion flagged with `eng_err` ends the exchange with `err_code`=2, and no further request is issued.
- R10: Every response byte appears once on `rsp_byte` with `rsp_vld` and its position on `rsp_idx`. On success `rsp_len` holds the response length and `err_code` is 0. On any error `rsp_len` is 0.
- R11: `req_len` lies between 1 and 64 while `req_vld` is high. Direction, address and length stay stable until `req_rdy` accepts the request.
- R12: During and after reset, and after a reset in mid-exchange, `busy`, `done` and `req_vld` are low and `err_code` is 0.
- R13: `done` is a one-cycle pulse at the end of every exchange, and `err_code` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (while idle) |
| cmd_len | input | LEN_W | Command length in bytes |
| rsp_max | input | LEN_W | Host response buffer limit in bytes |
| cmd_idx | output | LEN_W | Index of the command byte wanted |
| cmd_byte | input | 8 | Command byte at `cmd_idx`, same cycle |
| req_vld | output | 1 | Register request valid |
| req_rdy | input | 1 | Engine accepts the request |
| req_wr | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | ADDR_W | Register address |
| req_len | output | 7 | Byte count, 1..64 |
| wr_pull | input | 1 | Engine takes `wr_data` this cycle |
| wr_data | output | 8 | Next byte of the current write |
| rd_vld | input | 1 | Engine delivers `rd_data` this cycle |
| rd_data | input | 8 | Byte of the current read |
| eng_done | input | 1 | Transaction complete, one cycle after the last data beat |
| eng_err | input | 1 | Transaction failed, qualified by `eng_done` |
| rsp_vld | output | 1 | Response byte valid |
| rsp_idx | output | LEN_W | Position of the response byte |
| rsp_byte | output | 8 | Response byte |
| rsp_len | output | LEN_W | Response length of the last exchange |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Exchange finished (one cycle) |
| err_code | output | 3 | 0 ok, 1 length, 2 access, 3 timeout, 4 response length, 5 intermediate status, 6 final status |

## Verification
Command sizes are run against burst counts above 64, equal to it and far below it, so the three-way chunk minimum selects each of its terms in turn. A 7-byte response isolates the path where no body chunk precedes the single last-byte read. A response exactly at the host limit is run alongside one a byte over it. A poll count one short of the limit is run against one equal to it, which places the timeout boundary precisely. Status faults before and after the last byte, an engine fault mid-command and a bad encoded length each map to a distinct error code. Leading zero-burst reads show that no FIFO access starts on a zero count.

// File: rtl/tpm_fifo_xchg_pkg.sv
package tpm_fifo_xchg_pkg;

  typedef enum logic [2:0] {
    XE_NONE     = 3'd0,
    XE_LEN      = 3'd1,
    XE_ACCESS   = 3'd2,
    XE_TIMEOUT  = 3'd3,
    XE_TOO_LONG = 3'd4,
    XE_MID      = 3'd5,
    XE_FINAL    = 3'd6
  } xchg_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LCHK, S_CRDY, S_TXBC, S_TXDAT, S_GO, S_WAIT, S_POLL,
    S_HDR, S_RXBC, S_RXDAT, S_MID, S_LAST, S_FIN, S_IDLEWR, S_END
  } xchg_st_e;

  localparam logic [11:0] OFS_STATUS = 12'h018;
  localparam logic [11:0] OFS_FIFO   = 12'h024;
  localparam logic [7:0]  STV_CMD_READY = 8'h40;
  localparam logic [7:0]  STV_GO        = 8'h20;
  localparam int          BIT_VALID = 7;
  localparam int          BIT_AVAIL = 4;
  localparam int          BURST_LSB = 8;
  localparam int          BURST_W   = 16;
  localparam int          FRAME_MAX = 64;
  localparam int          HDR_BYTES = 6;

endpackage

// File: rtl/tfx_chunk_calc.sv
module tfx_chunk_calc #(
  parameter int REM_W = 16,
  parameter int BC_W  = 16,
  parameter int LIMIT = 64
) (
  input  logic [REM_W-1:0] remain,
  input  logic [BC_W-1:0]  burst,
  output logic [6:0]       chunk
);
  localparam int W = (REM_W > BC_W) ? REM_W : BC_W;

  logic [W-1:0] rem_w, bc_w, low;

  always_comb begin
    rem_w = W'(remain);
    bc_w  = W'(burst);
    low   = (rem_w < bc_w) ? rem_w : bc_w;
    chunk = (low > W'(LIMIT)) ? 7'(LIMIT) : low[6:0];
  end
endmodule

// File: rtl/tfx_status_cap.sv
module tfx_status_cap (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  output logic [31:0] word
);
  logic [7:0] lane_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   lane_q[g] <= '0;
      else if (en && lane == 2'(g)) lane_q[g] <= din;
    end
  end

  assign word = {lane_q[3], lane_q[2], lane_q[1], lane_q[0]};
endmodule

// File: rtl/tfx_poll_timer.sv
module tfx_poll_timer #(
  parameter int GAP   = 50000,
  parameter int MAXP  = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic poll_fail,
  output logic gap_done,
  output logic exhausted
);
  localparam int GW = $clog2(GAP + 1);
  localparam int PW = $clog2(MAXP + 1);

  logic [GW-1:0] gap_q, gap_d;
  logic [PW-1:0] poll_q, poll_d;

  always_comb begin
    gap_d  = run ? gap_q + GW'(1) : '0;
    poll_d = clr ? '0 : (poll_fail ? poll_q + PW'(1) : poll_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      poll_q <= '0;
    end else begin
      if (run || gap_q != '0) gap_q <= gap_d;
      if (clr || poll_fail)   poll_q <= poll_d;
    end
  end

  assign gap_done  = run && (gap_q == GW'(GAP - 1));
  assign exhausted = (poll_q == PW'(MAXP));

  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= PW'(MAXP));
endmodule

// File: rtl/tpm_fifo_xchg.sv
module tpm_fifo_xchg
  import tpm_fifo_xchg_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter logic [23:0]     LOC_BASE  = 24'hD4_0000,
  parameter int              LEN_W     = 16,
  parameter int              POLL_GAP  = 50000,
  parameter int              MAX_POLLS = 120000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [LEN_W-1:0]  rsp_max,
  output logic [LEN_W-1:0]  cmd_idx,
  input  logic [7:0]        cmd_byte,
  output logic              req_vld,
  input  logic              req_rdy,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [6:0]        req_len,
  input  logic              wr_pull,
  output logic [7:0]        wr_data,
  input  logic              rd_vld,
  input  logic [7:0]        rd_data,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              rsp_vld,
  output logic [LEN_W-1:0]  rsp_idx,
  output logic [7:0]        rsp_byte,
  output logic [LEN_W-1:0]  rsp_len,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code
);
  localparam logic [LEN_W-1:0] HDR_L = LEN_W'(HDR_BYTES);

  logic [1:0] rsync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];

  xchg_st_e         st, st_nx;
  logic             issued, issued_nx;
  logic [6:0]       xcnt, xcnt_nx, chunk_len, chunk_nx, chunk_calc;
  logic [LEN_W-1:0] pos, pos_nx, rsp_len_q, rsp_len_nx, chunk_rem;
  logic [31:0]      enc_len, enc_nx, rsp_tot, tot_nx, sts;
  xchg_err_e        err_q, err_nx;

  logic        op_act, op_rd, op_fifo, op_done, beat;
  logic [6:0]  op_len;
  logic [7:0]  op_wval;
  logic        sts_en, mid_ok, fin_ok, gap_done, exhausted, poll_fail, tmr_clr;
  logic [LEN_W-1:0] tx_rem, rx_rem, pos_step, tot_l;
  logic        unused_sts;

  // Operation issued by each state
  always_comb begin
    op_act = 1'b1; op_rd = 1'b1; op_fifo = 1'b0; op_len = 7'd4; op_wval = 8'h00;
    unique case (st)
      S_CRDY, S_IDLEWR: begin op_rd = 1'b0; op_len = 7'd1; op_wval = STV_CMD_READY; end
      S_GO:             begin op_rd = 1'b0; op_len = 7'd1; op_wval = STV_GO; end
      S_TXBC, S_RXBC, S_POLL, S_MID, S_FIN: ;
      S_TXDAT:          begin op_rd = 1'b0; op_fifo = 1'b1; op_len = chunk_len; end
      S_HDR:            begin op_fifo = 1'b1; op_len = 7'(HDR_BYTES); end
      S_RXDAT:          begin op_fifo = 1'b1; op_len = chunk_len; end
      S_LAST:           begin op_fifo = 1'b1; op_len = 7'd1; end
      default:          op_act = 1'b0;
    endcase
  end

  assign req_vld  = op_act && !issued;
  assign req_wr   = !op_rd;
  assign req_len  = op_len;
  assign req_addr = ADDR_W'(LOC_BASE) + ADDR_W'(op_fifo ? OFS_FIFO : OFS_STATUS);
  assign op_done  = op_act && issued && eng_done;
  assign beat     = op_act && issued && (wr_pull || rd_vld);
  assign wr_data  = (st == S_TXDAT) ? cmd_byte : op_wval;
  assign cmd_idx  = (st == S_LCHK) ? LEN_W'(2) + LEN_W'(xcnt) : pos + LEN_W'(xcnt);

  assign rsp_vld  = issued && rd_vld && (st == S_HDR || st == S_RXDAT || st == S_LAST);
  assign rsp_idx  = pos + LEN_W'(xcnt);
  assign rsp_byte = rd_data;

  assign sts_en   = op_act && issued && rd_vld && !op_fifo && (xcnt < 7'd4);
  assign mid_ok   = sts[BIT_VALID] && sts[BIT_AVAIL];
  assign fin_ok   = sts[BIT_VALID] && !sts[BIT_AVAIL];
  assign unused_sts = ^{sts[31:24], sts[6:5], sts[3:0]};

  assign tot_l    = rsp_tot[LEN_W-1:0];
  assign tx_rem   = cmd_len - pos;
  assign rx_rem   = tot_l - LEN_W'(1) - pos;
  assign chunk_rem = (st == S_RXBC) ? rx_rem : tx_rem;
  assign pos_step = pos + LEN_W'(chunk_len);

  assign poll_fail = (st == S_POLL) && op_done && !eng_err && !mid_ok;
  assign tmr_clr   = (st == S_GO) && op_done;

  tfx_status_cap u_cap (
    .clk(clk), .rst_n(rst_q), .en(sts_en), .lane(xcnt[1:0]), .din(rd_data), .word(sts)
  );

  tfx_chunk_calc #(.REM_W(LEN_W), .BC_W(BURST_W), .LIMIT(FRAME_MAX)) u_chunk (
    .remain(chunk_rem), .burst(sts[BURST_LSB +: BURST_W]), .chunk(chunk_calc)
  );

  tfx_poll_timer #(.GAP(POLL_GAP), .MAXP(MAX_POLLS)) u_tmr (
    .clk(clk), .rst_n(rst_q), .clr(tmr_clr), .run(st == S_WAIT),
    .poll_fail(poll_fail), .gap_done(gap_done), .exhausted(exhausted)
  );

  // Next-state process
  always_comb begin
    st_nx = st; issued_nx = issued; xcnt_nx = xcnt; pos_nx = pos;
    chunk_nx = chunk_len; enc_nx = enc_len; tot_nx = rsp_tot;
    err_nx = err_q; rsp_len_nx = rsp_len_q;

    if (req_vld && req_rdy) begin issued_nx = 1'b1; xcnt_nx = '0; end
    if (beat) xcnt_nx = xcnt + 7'd1;
    if (beat && st == S_HDR && xcnt >= 7'd2 && xcnt < 7'd6) tot_nx = {rsp_tot[23:0], rd_data};

    if (op_done) begin
      issued_nx = 1'b0;
      if (eng_err) begin
        err_nx = XE_ACCESS; st_nx = S_END;
      end else begin
        unique case (st)
          S_CRDY: st_nx = S_TXBC;
          S_TXBC, S_RXBC:
            if (sts[BURST_LSB +: BURST_W] != '0) begin
              chunk_nx = chunk_calc;
              st_nx    = (st == S_TXBC) ? S_TXDAT : S_RXDAT;
            end
          S_TXDAT: begin
            pos_nx = pos_step;
            st_nx  = (pos_step == cmd_len) ? S_GO : S_TXBC;
          end
          S_GO: st_nx = S_WAIT;
          S_POLL:
            if (mid_ok) begin pos_nx = '0; st_nx = S_HDR; end
            else st_nx = S_WAIT;
          S_HDR:
            if (rsp_tot > 32'(rsp_max) || rsp_tot < 32'(HDR_BYTES + 1)) begin
              err_nx = XE_TOO_LONG; st_nx = S_END;
            end else begin
              pos_nx = HDR_L;
              st_nx  = (rsp_tot == 32'(HDR_BYTES + 1)) ? S_MID : S_RXBC;
            end
          S_RXDAT: begin
            pos_nx = pos_step;
            st_nx  = (pos_step == tot_l - LEN_W'(1)) ? S_MID : S_RXBC;
          end
          S_MID:
            if (mid_ok) st_nx = S_LAST;
            else begin err_nx = XE_MID; st_nx = S_END; end
          S_LAST: st_nx = S_FIN;
          S_FIN:
            if (fin_ok) st_nx = S_IDLEWR;
            else begin err_nx = XE_FINAL; st_nx = S_END; end
          S_IDLEWR: begin rsp_len_nx = tot_l; st_nx = S_END; end
          default: ;
        endcase
      end
    end

    unique case (st)
      S_IDLE:
        if (start) begin
          st_nx = S_LCHK; xcnt_nx = '0; err_nx = XE_NONE; rsp_len_nx = '0;
        end
      S_LCHK:
        if (xcnt == 7'd4) begin
          if (enc_len != 32'(cmd_len) || cmd_len < HDR_L) begin
            err_nx = XE_LEN; st_nx = S_END;
          end else begin
            pos_nx = '0; st_nx = S_CRDY;
          end
        end else begin
          enc_nx  = {enc_len[23:0], cmd_byte};
          xcnt_nx = xcnt + 7'd1;
        end
      S_WAIT:
        if (gap_done) begin
          if (exhausted) begin err_nx = XE_TIMEOUT; st_nx = S_END; end
          else st_nx = S_POLL;
        end
      S_END: st_nx = S_IDLE;
      default: ;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st <= S_IDLE; issued <= 1'b0; xcnt <= '0; pos <= '0; chunk_len <= '0;
      enc_len <= '0; rsp_tot <= '0; err_q <= XE_NONE; rsp_len_q <= '0;
    end else begin
      st <= st_nx; issued <= issued_nx; xcnt <= xcnt_nx; pos <= pos_nx;
      chunk_len <= chunk_nx; enc_len <= enc_nx; rsp_tot <= tot_nx;
      err_q <= err_nx; rsp_len_q <= rsp_len_nx;
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_END);
  assign err_code = err_q;
  assign rsp_len  = rsp_len_q;

  // R11
  req_len_range_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_vld |-> (req_len >= 7'd1 && req_len <= 7'(FRAME_MAX)));
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (req_vld && !req_rdy) |=> (req_vld && $stable(req_addr) && $stable(req_len) && $stable(req_wr)));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);
  // R3
  burst_before_fifo_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_TXDAT && $past(st) != S_TXDAT) |-> ($past(st) == S_TXBC && $past(op_done)));
  // R4
  chunk_fit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_TXDAT) |-> (pos_step <= cmd_len && chunk_len != 7'd0));
  // R8
  last_after_mid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st == S_LAST && $past(st) != S_LAST) |-> ($past(st) == S_MID));
endmodule

// File: tb/tpm_fifo_xchg_bench.sv
module tpm_fifo_xchg_bench;
  localparam int LW = 16;
  localparam int GAP = 4;
  localparam int MAXP = 5;
  localparam int NV = 12;
  // clen, len_delta, burst, zero_bursts, busy_polls, rlen, rmax, fault, err_at, exp_err
  localparam int VEC [NV][10] = '{
    '{ 10, 0,  64, 0, 0,  10, 100, 0, 0, 0},
    '{150, 0,  64, 0, 1, 140, 200, 0, 0, 0},
    '{ 30, 0,   7, 2, 3,  40,  40, 0, 0, 0},
    '{200, 0, 100, 0, 4, 200, 255, 0, 0, 0},
    '{ 12, 1,  64, 0, 0,  10, 100, 0, 0, 1},
    '{ 12, 0,  64, 0, 5,  10, 100, 0, 0, 3},
    '{ 12, 0,  64, 0, 0,  50,  49, 0, 0, 4},
    '{  8, 0,   3, 0, 0,   7, 100, 0, 0, 0},
    '{ 20, 0,  16, 0, 0,  30, 100, 1, 0, 5},
    '{ 20, 0,  16, 0, 0,  30, 100, 2, 0, 6},
    '{ 20, 0,  16, 0, 0,  30, 100, 0, 3, 2},
    '{ 12, 0,  64, 0, 0,   6, 100, 0, 0, 4}
  };

  logic clk, rst_n, start;
  logic [LW-1:0] cmd_len, rsp_max, cmd_idx, rsp_idx, rsp_len;
  logic [7:0] cmd_byte, wr_data, rd_data, rsp_byte;
  logic req_vld, req_rdy, req_wr, wr_pull, rd_vld, eng_done, eng_err;
  logic rsp_vld, busy, done;
  logic [23:0] req_addr;
  logic [6:0] req_len;
  logic [2:0] err_code;

  logic [7:0] cmd_mem [256];
  logic [7:0] rsp_mem [256];

  int nchk = 0, nerr = 0, cyc = 0;
  int cfg_burst, cfg_zb, cfg_busy, cfg_fault, cfg_err_at, clen, rlen;
  int eph, ek, elen, hold, trans, wptr, rptr, polls_left, polls_seen;
  int idle_wr, chunk_bad, wbad, rbad, zb_left;
  bit ewr, efifo, go_seen;
  logic [31:0] stv;

  tpm_fifo_xchg #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_tpm_fifo_xchg (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .rsp_max(rsp_max),
    .cmd_idx(cmd_idx), .cmd_byte(cmd_byte), .req_vld(req_vld), .req_rdy(req_rdy),
    .req_wr(req_wr), .req_addr(req_addr), .req_len(req_len), .wr_pull(wr_pull),
    .wr_data(wr_data), .rd_vld(rd_vld), .rd_data(rd_data), .eng_done(eng_done),
    .eng_err(eng_err), .rsp_vld(rsp_vld), .rsp_idx(rsp_idx), .rsp_byte(rsp_byte),
    .rsp_len(rsp_len), .busy(busy), .done(done), .err_code(err_code)
  );

  assign cmd_byte = cmd_mem[cmd_idx[7:0]];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int min3(input int a, input int b, input int c);
    int m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic logic [31:0] status_word();
    bit av;
    int b = (zb_left > 0) ? 0 : cfg_burst;
    if (!go_seen || polls_left > 0) av = 0;
    else av = (rptr < rlen);
    if (cfg_fault == 1 && rptr == rlen - 1) av = 0;
    if (cfg_fault == 2 && rptr == rlen) av = 1;
    return {8'h00, 16'(b), 8'h80 | (av ? 8'h10 : 8'h00)};
  endfunction

  // Behavioural register engine and device model, driven on the falling edge
  always @(negedge clk) begin
    req_rdy = 0; wr_pull = 0; rd_vld = 0; eng_done = 0; eng_err = 0;
    if (!rst_n) eph = 0;
    else case (eph)
      0: if (req_vld) begin
        if (hold == 0) hold = 1;
        else begin
          hold = 0; req_rdy = 1; trans++;
          ewr = req_wr; elen = int'(req_len); ek = 0; eph = 1;
          efifo = (req_addr == 24'hD4_0024);
          if (efifo && ewr && elen != min3(clen - wptr, cfg_burst, 64)) chunk_bad++;
          if (efifo && !ewr && rptr != 0 && rptr != rlen - 1 &&
              elen != min3(rlen - 1 - rptr, cfg_burst, 64)) chunk_bad++;
        end
      end
      1: begin
        if (ewr) begin
          wr_pull = 1;
          if (efifo) begin
            if (wr_data != cmd_mem[wptr]) wbad++;
            wptr++;
          end else if (ek == 0) begin
            if (wr_data == 8'h40) idle_wr++;
            if (wr_data == 8'h20) begin go_seen = 1; polls_left = cfg_busy; end
          end
        end else begin
          rd_vld = 1;
          if (efifo) begin
            rd_data = rsp_mem[rptr];
            #1;
            if (!rsp_vld || rsp_idx != LW'(rptr) || rsp_byte != rsp_mem[rptr]) rbad++;
            rptr++;
          end else begin
            if (ek == 0) begin
              stv = status_word();
              if (zb_left > 0) zb_left--;
              if (go_seen && rptr == 0) begin
                polls_seen++;
                if (polls_left > 0) polls_left--;
              end
            end
            rd_data = stv[8*ek +: 8];
          end
        end
        ek++;
        if (ek == elen) eph = 2;
      end
      default: begin
        eng_done = 1; eng_err = (trans == cfg_err_at); eph = 0;
      end
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic setup(input int v);
    clen = VEC[v][0]; cfg_burst = VEC[v][2]; cfg_zb = VEC[v][3]; cfg_busy = VEC[v][4];
    rlen = VEC[v][5]; cfg_fault = VEC[v][7]; cfg_err_at = VEC[v][8];
    for (int i = 0; i < 256; i++) begin
      cmd_mem[i] = 8'(i * 29 + 1);
      rsp_mem[i] = 8'(i * 13 + 5);
    end
    {cmd_mem[2], cmd_mem[3], cmd_mem[4], cmd_mem[5]} = 32'(clen + VEC[v][1]);
    {rsp_mem[2], rsp_mem[3], rsp_mem[4], rsp_mem[5]} = 32'(rlen);
    trans = 0; wptr = 0; rptr = 0; polls_left = 0; polls_seen = 0; idle_wr = 0;
    chunk_bad = 0; wbad = 0; rbad = 0; zb_left = cfg_zb; go_seen = 0; hold = 0;
    cmd_len = LW'(clen); rsp_max = LW'(VEC[v][6]);
  endtask

  task automatic run_and_wait(output bit fin);
    int n = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    fin = done;
  endtask

  initial begin
    bit fin;
    rst_n = 0; start = 0; cmd_len = '0; rsp_max = '0;
    rd_data = 8'h00; eph = 0; hold = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(busy == 0, "R12 busy", busy, 0);
    chk(req_vld == 0, "R12 req_vld", req_vld, 0);
    chk(done == 0, "R12 done", done, 0);
    chk(err_code == 0, "R12 err_code", err_code, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int ee;
      ee = VEC[v][9];
      setup(v);
      @(negedge clk);
      run_and_wait(fin);
      chk(fin, "R13 exchange completes", fin, 1);
      chk(err_code == 3'(ee), "R9 err_code per cause (R1 R5 R6 R7 R8)", err_code, ee);
      @(negedge clk);
      chk(done == 0, "R13 done one cycle", done, 0);
      if (ee == 0) begin
        chk(rsp_len == LW'(rlen), "R10 rsp_len", rsp_len, rlen);
        chk(rbad == 0 && rptr == rlen, "R10 response bytes", rptr - rbad, rlen);
        chk(wbad == 0 && wptr == clen, "R2 command bytes", wptr - wbad, clen);
        chk(chunk_bad == 0, "R4 chunk sizes", chunk_bad, 0);
        chk(idle_wr == 2, "R2 command-ready writes", idle_wr, 2);
        chk(polls_seen == cfg_busy + 1, "R5 poll count", polls_seen, cfg_busy + 1);
        if (cfg_zb > 0) chk(zb_left == 0, "R3 zero burst reads repeated", zb_left, 0);
      end else begin
        chk(rsp_len == 0, "R10 rsp_len zero on error", rsp_len, 0);
        if (ee == 1) chk(trans == 0, "R1 no request on refusal", trans, 0);
        if (ee == 3) chk(polls_seen == MAXP, "R5 polls before timeout", polls_seen, MAXP);
        if (ee == 2) chk(trans == cfg_err_at, "R9 no request after fault", trans, cfg_err_at);
        if (ee >= 4) chk(idle_wr == 1, "R8 no idle write after error", idle_wr, 1);
        if (ee == 5) chk(rptr == rlen - 1, "R7 last byte withheld", rptr, rlen - 1);
      end
      if (ee == 6) chk(rptr == rlen, "R8 last byte read alone", rptr, rlen);
    end

    // R12: reset in mid-exchange
    setup(1);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (40) @(negedge clk);
    rst_n = 0;
    #1;
    chk(busy == 0 && req_vld == 0, "R12 mid reset idle", busy, 0);
    repeat (3) @(negedge clk);
    chk(err_code == 0 && done == 0, "R12 mid reset outputs", err_code, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    setup(0);
    @(negedge clk);
    run_and_wait(fin);
    chk(fin && err_code == 0 && rsp_len == 10, "R12 exchange after reset", rsp_len, 10);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule